// File: doc/BRIEF.md
# Subsystem Power State Controller

This block is a register-mapped controller that keeps a 2-bit power state for each of a set of logical subsystems (64 by default). Software places the states it wants into a bank of control registers, then writes a command word. While the command runs, the controller raises a busy flag for a fixed number of cycles. When a set-configuration command in immediate mode finishes, the requested states are moved into a separate read-only status bank. That status bank also drives the per-subsystem state outputs.

The controller also holds wake-enable registers. A wake event on an enabled source sets a sticky wake-status bit, which software clears by writing 1 to it. An interrupt register holds an enable bit, a pending bit and an 8-bit cause code. The interrupt output is high when pending and enable are both set. Delayed and trigger command modes, and command codes other than set-configuration, are accepted and acknowledged but have no effect on the states.

Top module: `subsys_pwr_ctrl`

## Requirements
- R1: After reset, every state-control register (word offsets 0x20, 0x24, 0x28, 0x2C) and every state-status register (0x30, 0x34, 0x38, 0x3C) reads 0xFFFFFFFF. The wake-control registers (0x10, 0x14), the status register (0x00), the command register (0x04) and the interrupt register (0x08) read 0, and `irq_o` is low.
- R2: A state-control register reads back the last value written to it. A write to a state-status register changes nothing. A write to a state-control register does not change the state-status bank.
- R3: A command write accepted while idle sets busy (bit 8 of 0x00) for exactly BUSY_CYCLES clock edges. The edge that captures the write counts as the first of these edges.
- R4: Command word fields: code in bits 7:0, completion-interrupt request in bit 8, mode in bits 10:9 (0 no-op, 1 immediate, 2 delayed, 3 trigger). With code 0x01 and mode 1, the state-control bank is copied into the state-status bank on the edge where busy clears. The state-status bank keeps its old value while busy is set.
- R5: A command with any other code, or with mode 0, 2 or 3, still sets busy, but it leaves the state-status bank unchanged.
- R6: When busy clears and the command had bit 8 set, the interrupt register gets pending (bit 9) set and cause (bits 7:0) equal to 1. Without bit 8, pending stays clear.
- R7: A command write while busy is ignored: the command register keeps the running command, and that command still completes. The ignored write sets pending with cause 2.
- R8: Interrupt register bit 8 is a read/write enable. Writing 1 to bit 9 clears pending. `irq_o` equals pending AND enable.
- R9: The wake-control registers are read/write. Bit k of `wake_evt_i` sets wake-status bit k (registers 0x18, 0x1C; bit k is bit k mod 32 of register k/32) only while wake-control bit k is set. Writing 1 to a wake-status bit clears it.
- R10: Subsystem n has its field at bits 2(n mod 16)+1 : 2(n mod 16) of state register n/16. `subsys_state_o[2n+1:2n]` equals that field of the state-status bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_i | input | 1 | Write strobe, one cycle per write |
| bus_addr_i | input | 8 | Byte address, word-aligned accesses only |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i, combinational |
| wake_evt_i | input | N_WAKE | Wake event sources, one bit per source |
| subsys_state_o | output | 2*N_SUBSYS | Applied power state per subsystem |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume the following about the inputs: each write strobe is a single clean cycle with a stable address and data, BUSY_CYCLES is at least one, and a wake event may arrive in any cycle. They do not assume that software waits for busy to clear. A write during busy is legal and must be flagged as an error. The stimulus drives every bus access half a cycle away from the clock edge. Any register read comes one full cycle after the write it observes. The stimulus never clears pending in the same cycle that a completion or an error sets it, so each expected value has a single meaning.

// File: rtl/spc_pkg.sv
package spc_pkg;
    localparam int REG_W   = 32;
    localparam int FIELD_W = 2;

    // word indices (byte address bits 7:2)
    localparam logic [5:0] W_STATUS = 6'd0;
    localparam logic [5:0] W_CMD    = 6'd1;
    localparam logic [5:0] W_ICS    = 6'd2;
    localparam logic [5:0] W_WKC    = 6'd4;
    localparam logic [5:0] W_WKS    = 6'd6;
    localparam logic [5:0] W_SSC    = 6'd8;
    localparam logic [5:0] W_SSS    = 6'd12;

    localparam int BUSY_BIT = 8;
    localparam int IE_BIT   = 8;
    localparam int IP_BIT   = 9;

    typedef enum logic [1:0] {
        MODE_NOP = 2'd0,
        MODE_IMM = 2'd1,
        MODE_DLY = 2'd2,
        MODE_TRG = 2'd3
    } cmd_mode_e;

    typedef struct packed {
        logic [20:0] rsvd;
        cmd_mode_e   mode;
        logic        ioc;
        logic [7:0]  code;
    } cmd_word_t;

    localparam logic [7:0] CODE_SET_CFG  = 8'h01;
    localparam logic [7:0] CAUSE_DONE    = 8'd1;
    localparam logic [7:0] CAUSE_CMD_ERR = 8'd2;
endpackage

// File: rtl/spc_cmd_engine.sv
module spc_cmd_engine
    import spc_pkg::*;
#(
    parameter int BUSY_CYCLES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_wr_i,
    input  logic [REG_W-1:0] cmd_wdata_i,
    output logic             busy_o,
    output logic [REG_W-1:0] cmd_o,
    output logic             done_o,
    output logic             apply_o,
    output logic             ioc_o,
    output logic             err_o
);
    localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        cmd_word_t        cmd;
    } eng_t;

    eng_t s_d, s_q;
    logic accept;

    always_comb begin
        s_d    = s_q;
        accept = cmd_wr_i && (s_q.cnt == '0);
        if (s_q.cnt != '0) begin
            s_d.cnt = s_q.cnt - 1'b1;
        end
        if (accept) begin
            s_d.cnt = CNT_W'(BUSY_CYCLES);
            s_d.cmd = cmd_word_t'(cmd_wdata_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy_o  = (s_q.cnt != '0);
    assign done_o  = (s_q.cnt == CNT_W'(1));
    assign apply_o = done_o && (s_q.cmd.code == CODE_SET_CFG) && (s_q.cmd.mode == MODE_IMM);
    assign ioc_o   = s_q.cmd.ioc;
    assign err_o   = cmd_wr_i && busy_o;
    assign cmd_o   = s_q.cmd;

    // R3: an idle write starts the busy window and latches the word
    p_accept_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr_i && !busy_o) |=> (busy_o && cmd_o == $past(cmd_wdata_i)));

    // R3: the last busy cycle is followed by idle
    p_done_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !busy_o);

    // R7: a write during busy leaves the running command in place
    p_busy_ignore_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr_i && busy_o) |=> (cmd_o == $past(cmd_o)));
endmodule

// File: rtl/spc_state_bank.sv
module spc_state_bank
    import spc_pkg::*;
#(
    parameter int N_REGS = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [N_REGS-1:0]            wr_i,
    input  logic [REG_W-1:0]             wdata_i,
    input  logic                         apply_i,
    output logic [N_REGS-1:0][REG_W-1:0] ctrl_o,
    output logic [N_REGS-1:0][REG_W-1:0] status_o
);
    typedef struct packed {
        logic [N_REGS-1:0][REG_W-1:0] ctrl;
        logic [N_REGS-1:0][REG_W-1:0] status;
    } bank_t;

    bank_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        for (int i = 0; i < N_REGS; i++) begin
            if (wr_i[i]) s_d.ctrl[i] = wdata_i;
        end
        if (apply_i) s_d.status = s_q.ctrl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '1;
        else        s_q <= s_d;
    end

    assign ctrl_o   = s_q.ctrl;
    assign status_o = s_q.status;

    // R4: the applied bank equals the requested bank seen at completion
    p_apply_copy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        apply_i |=> (status_o == $past(ctrl_o)));

    // R2/R5: the status bank moves only on an apply
    p_status_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !apply_i |=> $stable(status_o));
endmodule

// File: rtl/spc_wake.sv
module spc_wake
    import spc_pkg::*;
#(
    parameter int N_REGS = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [N_REGS-1:0]            ctl_wr_i,
    input  logic [N_REGS-1:0]            sts_wr_i,
    input  logic [REG_W-1:0]             wdata_i,
    input  logic [N_REGS*REG_W-1:0]      evt_i,
    output logic [N_REGS-1:0][REG_W-1:0] ctrl_o,
    output logic [N_REGS-1:0][REG_W-1:0] status_o
);
    typedef struct packed {
        logic [N_REGS-1:0][REG_W-1:0] ctrl;
        logic [N_REGS-1:0][REG_W-1:0] status;
    } wake_t;

    wake_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        for (int i = 0; i < N_REGS; i++) begin
            if (ctl_wr_i[i]) s_d.ctrl[i] = wdata_i;
            if (sts_wr_i[i]) s_d.status[i] = s_q.status[i] & ~wdata_i;
            s_d.status[i] = s_d.status[i] | (evt_i[i*REG_W +: REG_W] & s_q.ctrl[i]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ctrl_o   = s_q.ctrl;
    assign status_o = s_q.status;

    logic [N_REGS*REG_W-1:0] hit, sts_flat;
    assign hit      = evt_i & s_q.ctrl;
    assign sts_flat = s_q.status;

    // R9: an enabled event is captured on the next edge
    p_wake_latch_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (|hit) |=> ((sts_flat & $past(hit)) == $past(hit)));
endmodule

// File: rtl/spc_irq.sv
module spc_irq
    import spc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ics_wr_i,
    input  logic       ie_wdata_i,
    input  logic       ip_clr_i,
    input  logic       done_i,
    input  logic       ioc_i,
    input  logic       err_i,
    output logic       ie_o,
    output logic       ip_o,
    output logic [7:0] cause_o,
    output logic       irq_o
);
    typedef struct packed {
        logic       ie;
        logic       ip;
        logic [7:0] cause;
    } ics_t;

    ics_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (ics_wr_i) begin
            s_d.ie = ie_wdata_i;
            if (ip_clr_i) s_d.ip = 1'b0;
        end
        if (done_i && ioc_i) begin
            s_d.ip    = 1'b1;
            s_d.cause = CAUSE_DONE;
        end
        if (err_i) begin
            s_d.ip    = 1'b1;
            s_d.cause = CAUSE_CMD_ERR;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ie_o    = s_q.ie;
    assign ip_o    = s_q.ip;
    assign cause_o = s_q.cause;
    assign irq_o   = s_q.ip & s_q.ie;

    // R6: requested completion raises pending with the done cause
    p_done_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && ioc_i && !err_i) |=> (ip_o && cause_o == CAUSE_DONE));

    // R7: a rejected command raises pending with the error cause
    p_err_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err_i |=> (ip_o && cause_o == CAUSE_CMD_ERR));

    // R8: pending never rises without a source event
    p_ip_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ip_o) |-> $past((done_i && ioc_i) || err_i));
endmodule

// File: rtl/subsys_pwr_ctrl.sv
module subsys_pwr_ctrl
    import spc_pkg::*;
#(
    parameter int N_SUBSYS    = 64,
    parameter int N_WAKE      = 64,
    parameter int BUSY_CYCLES = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bus_wr_i,
    input  logic [7:0]                  bus_addr_i,
    input  logic [REG_W-1:0]            bus_wdata_i,
    output logic [REG_W-1:0]            bus_rdata_o,
    input  logic [N_WAKE-1:0]           wake_evt_i,
    output logic [FIELD_W*N_SUBSYS-1:0] subsys_state_o,
    output logic                        irq_o
);
    localparam int N_STATE_REGS = (N_SUBSYS * FIELD_W) / REG_W;
    localparam int N_WAKE_REGS  = N_WAKE / REG_W;

    logic       aligned, wr_ok;
    logic [5:0] word;

    assign aligned = (bus_addr_i[1:0] == 2'b00);
    assign word    = bus_addr_i[7:2];
    assign wr_ok   = bus_wr_i && aligned;

    logic [N_STATE_REGS-1:0] ssc_wr;
    logic [N_WAKE_REGS-1:0]  wkc_wr, wks_wr;

    for (genvar i = 0; i < N_STATE_REGS; i++) begin : g_ssc_dec
        assign ssc_wr[i] = wr_ok && (word == 6'(int'(W_SSC) + i));
    end
    for (genvar i = 0; i < N_WAKE_REGS; i++) begin : g_wake_dec
        assign wkc_wr[i] = wr_ok && (word == 6'(int'(W_WKC) + i));
        assign wks_wr[i] = wr_ok && (word == 6'(int'(W_WKS) + i));
    end

    logic             busy, done, apply, ioc, err;
    logic [REG_W-1:0] cmd_rd;

    spc_cmd_engine #(.BUSY_CYCLES(BUSY_CYCLES)) u_eng (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_wr_i    (wr_ok && (word == W_CMD)),
        .cmd_wdata_i (bus_wdata_i),
        .busy_o      (busy),
        .cmd_o       (cmd_rd),
        .done_o      (done),
        .apply_o     (apply),
        .ioc_o       (ioc),
        .err_o       (err)
    );

    logic [N_STATE_REGS-1:0][REG_W-1:0] ssc, sss;

    spc_state_bank #(.N_REGS(N_STATE_REGS)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (ssc_wr),
        .wdata_i  (bus_wdata_i),
        .apply_i  (apply),
        .ctrl_o   (ssc),
        .status_o (sss)
    );

    logic [N_WAKE_REGS-1:0][REG_W-1:0] wkc, wks;

    spc_wake #(.N_REGS(N_WAKE_REGS)) u_wake (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl_wr_i (wkc_wr),
        .sts_wr_i (wks_wr),
        .wdata_i  (bus_wdata_i),
        .evt_i    (wake_evt_i),
        .ctrl_o   (wkc),
        .status_o (wks)
    );

    logic       ie, ip;
    logic [7:0] cause;

    spc_irq u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .ics_wr_i   (wr_ok && (word == W_ICS)),
        .ie_wdata_i (bus_wdata_i[IE_BIT]),
        .ip_clr_i   (bus_wdata_i[IP_BIT]),
        .done_i     (done),
        .ioc_i      (ioc),
        .err_i      (err),
        .ie_o       (ie),
        .ip_o       (ip),
        .cause_o    (cause),
        .irq_o      (irq_o)
    );

    always_comb begin
        bus_rdata_o = '0;
        if (aligned) begin
            if (word == W_STATUS) bus_rdata_o[BUSY_BIT] = busy;
            if (word == W_CMD)    bus_rdata_o = cmd_rd;
            if (word == W_ICS)    bus_rdata_o = {22'b0, ip, ie, cause};
            for (int i = 0; i < N_WAKE_REGS; i++) begin
                if (word == 6'(int'(W_WKC) + i)) bus_rdata_o = wkc[i];
                if (word == 6'(int'(W_WKS) + i)) bus_rdata_o = wks[i];
            end
            for (int i = 0; i < N_STATE_REGS; i++) begin
                if (word == 6'(int'(W_SSC) + i)) bus_rdata_o = ssc[i];
                if (word == 6'(int'(W_SSS) + i)) bus_rdata_o = sss[i];
            end
        end
    end

    assign subsys_state_o = sss;

    // R10: outputs track the applied bank only after a completed apply
    p_out_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !apply |=> $stable(subsys_state_o));
endmodule

// File: tb/subsys_pwr_ctrl_bench.sv
module subsys_pwr_ctrl_bench;
    localparam int BUSY = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_wr = 1'b0;
    logic [7:0]   bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic [63:0]  wake_evt = '0;
    logic [127:0] sstate;
    logic         irq;

    subsys_pwr_ctrl #(.N_SUBSYS(64), .N_WAKE(64), .BUSY_CYCLES(BUSY)) u_subsys_pwr_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .bus_wr_i       (bus_wr),
        .bus_addr_i     (bus_addr),
        .bus_wdata_i    (bus_wdata),
        .bus_rdata_o    (bus_rdata),
        .wake_evt_i     (wake_evt),
        .subsys_state_o (sstate),
        .irq_o          (irq)
    );

    always #5 clk = ~clk;

    typedef struct {
        logic [7:0]  addr;
        logic [31:0] exp;
        string       tag;
    } sb_item_t;

    sb_item_t sb_q[$];
    int checks = 0;
    int fails  = 0;
    logic [31:0] m_ssc [4];

    // monitor: compares read data at the falling edge
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            sb_item_t it;
            it = sb_q.pop_front();
            checks++;
            if (bus_rdata !== it.exp) begin
                fails++;
                $display("FAIL %s addr=%h actual=%h expected=%h", it.tag, it.addr, bus_rdata, it.exp);
            end
        end
    end

    task automatic rd_exp(input logic [7:0] a, input logic [31:0] e, input string tag);
        sb_item_t it;
        @(posedge clk); #1;
        bus_addr = a;
        it.addr = a; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        @(negedge clk); #1;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input logic [127:0] act, input logic [127:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic void set_field(input int n, input logic [1:0] v);
        m_ssc[n / 16][2*(n % 16) +: 2] = v;
    endfunction

    initial begin
        #2_000_000;
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) m_ssc[i] = 32'hFFFF_FFFF;
        idle(3);
        #2 rst_n = 1'b1;
        idle(2);

        // R1 reset state
        for (int i = 0; i < 4; i++) begin
            rd_exp(8'(8'h20 + 4*i), 32'hFFFF_FFFF, "R1 ctrl reset");
            rd_exp(8'(8'h30 + 4*i), 32'hFFFF_FFFF, "R1 status reset");
        end
        rd_exp(8'h10, 32'h0, "R1 wake ctrl reset");
        rd_exp(8'h14, 32'h0, "R1 wake ctrl reset");
        rd_exp(8'h00, 32'h0, "R1 busy reset");
        rd_exp(8'h04, 32'h0, "R1 cmd reset");
        rd_exp(8'h08, 32'h0, "R1 ics reset");
        chk({127'b0, irq}, 128'h0, "R1 irq reset");
        chk(sstate, {128{1'b1}}, "R1 outputs reset");

        // R2 control readback, status bank read-only
        wr(8'h24, 32'h1234_5678);
        m_ssc[1] = 32'h1234_5678;
        rd_exp(8'h24, 32'h1234_5678, "R2 ctrl readback");
        rd_exp(8'h34, 32'hFFFF_FFFF, "R2 status untouched by ctrl write");
        wr(8'h34, 32'h0);
        rd_exp(8'h34, 32'hFFFF_FFFF, "R2 status write ignored");

        // R5 non-applying commands
        wr(8'h04, 32'h0000_0401);          // set-config, delayed mode
        rd_exp(8'h00, 32'h0000_0100, "R5 delayed accepted busy");
        idle(10);
        rd_exp(8'h34, 32'hFFFF_FFFF, "R5 delayed no apply");
        wr(8'h04, 32'h0000_0202);          // other code, immediate
        idle(10);
        rd_exp(8'h34, 32'hFFFF_FFFF, "R5 other code no apply");
        wr(8'h04, 32'h0000_0601);          // trigger mode
        idle(10);
        rd_exp(8'h34, 32'hFFFF_FFFF, "R5 trigger no apply");
        wr(8'h04, 32'h0000_0001);          // no-op mode
        idle(10);
        rd_exp(8'h34, 32'hFFFF_FFFF, "R5 nop mode no apply");
        chk(sstate, {128{1'b1}}, "R5 outputs unchanged");

        // R4 and R10: apply, status holds during busy
        set_field(37, 2'd1);
        set_field(0, 2'd0);
        set_field(63, 2'd2);
        wr(8'h20, m_ssc[0]);
        wr(8'h28, m_ssc[2]);
        wr(8'h2C, m_ssc[3]);
        wr(8'h04, 32'h0000_0201);
        for (int k = 1; k < BUSY; k++) rd_exp(8'h38, 32'hFFFF_FFFF, "R4 status held while busy");
        rd_exp(8'h38, m_ssc[2], "R4 status applied at completion");
        rd_exp(8'h30, m_ssc[0], "R4 status reg0 applied");
        rd_exp(8'h34, m_ssc[1], "R4 status reg1 applied");
        rd_exp(8'h3C, m_ssc[3], "R4 status reg3 applied");
        chk(sstate, {m_ssc[3], m_ssc[2], m_ssc[1], m_ssc[0]}, "R10 output vector");
        chk({126'b0, sstate[2*37 +: 2]}, 128'd1, "R10 subsystem 37 field");
        chk({126'b0, sstate[1:0]}, 128'd0, "R10 subsystem 0 field");
        chk({126'b0, sstate[2*63 +: 2]}, 128'd2, "R10 subsystem 63 field");

        // R3 exact busy length; R6 no pending without completion request
        wr(8'h04, 32'h0000_0201);
        for (int k = 1; k < BUSY; k++) rd_exp(8'h00, 32'h0000_0100, "R3 busy window");
        rd_exp(8'h00, 32'h0000_0000, "R3 busy cleared");
        rd_exp(8'h08, 32'h0000_0000, "R6 no pending without request");

        // R6 and R8 completion interrupt
        wr(8'h08, 32'h0000_0100);
        rd_exp(8'h08, 32'h0000_0100, "R8 enable readback");
        wr(8'h04, 32'h0000_0301);
        idle(BUSY + 1);
        rd_exp(8'h08, 32'h0000_0301, "R6 pending with done cause");
        chk({127'b0, irq}, 128'd1, "R8 irq with enable");
        wr(8'h08, 32'h0000_0300);
        rd_exp(8'h08, 32'h0000_0101, "R8 write-one clears pending");
        chk({127'b0, irq}, 128'd0, "R8 irq low after clear");
        wr(8'h08, 32'h0000_0000);
        wr(8'h04, 32'h0000_0301);
        idle(BUSY + 1);
        rd_exp(8'h08, 32'h0000_0201, "R6 pending with enable off");
        chk({127'b0, irq}, 128'd0, "R8 irq masked");
        wr(8'h08, 32'h0000_0300);
        rd_exp(8'h08, 32'h0000_0101, "R8 enable set pending cleared");

        // R7 command during busy
        m_ssc[3] = 32'hAAAA_AAAA;
        wr(8'h2C, m_ssc[3]);
        wr(8'h04, 32'h0000_0201);
        wr(8'h04, 32'h0000_0102);
        rd_exp(8'h04, 32'h0000_0201, "R7 running command kept");
        rd_exp(8'h08, 32'h0000_0302, "R7 error cause pending");
        chk({127'b0, irq}, 128'd1, "R7 irq on error");
        idle(BUSY + 1);
        rd_exp(8'h3C, 32'hAAAA_AAAA, "R7 running command completed");
        rd_exp(8'h08, 32'h0000_0302, "R7 no done cause without request");
        wr(8'h08, 32'h0000_0300);
        rd_exp(8'h08, 32'h0000_0102, "R7 error cleared");

        // R9 wake control and status
        wr(8'h10, 32'h0000_00F0);
        rd_exp(8'h10, 32'h0000_00F0, "R9 wake ctrl readback");
        @(posedge clk); #1 wake_evt = 64'hFF;
        @(posedge clk); #1 wake_evt = '0;
        rd_exp(8'h18, 32'h0000_00F0, "R9 only enabled sources latched");
        rd_exp(8'h1C, 32'h0000_0000, "R9 upper status untouched");
        wr(8'h18, 32'h0000_0030);
        rd_exp(8'h18, 32'h0000_00C0, "R9 write-one clears");
        wr(8'h14, 32'h0000_0100);
        @(posedge clk); #1 wake_evt = 64'h1 << 40;
        @(posedge clk); #1 wake_evt = '0;
        rd_exp(8'h1C, 32'h0000_0100, "R9 source 40 latched");

        idle(2);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule